// File: doc/BRIEF.md
# Clock Generator Power-Down and Lock-Wait Sequencer

This block controls when a clock generator is powered, when its output pad drives, and when the generated clock can be trusted. It watches an output-enable pin and the configuration pins: spread type, two rate-select bits and multiply select. It steps through three states: powered off, waiting for lock, and clock valid. While the enable is low, the oscillator and PLL are held in power-down and the output driver is off. While the enable is low, the configuration values passed on to the generator are also forced to zero.

Lock is not measured. The block waits a fixed number of timing-clock cycles, `LOCK_CYCLES`, after leaving power-down before it raises the valid flag. It starts the same full wait again whenever any configuration pin changes level. All pins pass through two-flop synchronizers. The enable is also filtered, so that a low pulse shorter than `MIN_LOW` cycles cannot cause a power-down. Logic downstream of the generator can use the valid flag to hold off its own reset until the clock has settled.

Top module: `clkgen_lockseq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs are `osc_pd`=1, `out_drive_en`=0 and `clk_valid`=0, and all three `eff_*` outputs are 0.
- R2: If the synchronized enable stays low for at least `MIN_LOW` consecutive cycles, the block powers down. `osc_pd` becomes 1 and `out_drive_en` and `clk_valid` become 0, no later than `MIN_LOW`+3 clock edges after the pin falls.
- R3: An enable low pulse shorter than `MIN_LOW` cycles is ignored. `clk_valid` and `out_drive_en` stay high throughout and afterwards.
- R4: While the block is powered down, `eff_spread`, `eff_rate` and `eff_mult` are 0 whatever the pins show. Once it is powered, they follow `spread_pin`, `rate_pin[1:0]` and `mult_pin` bit for bit.
- R5: After the enable pin rises from power-down, `out_drive_en` rises and `osc_pd` falls exactly 4 edges later. `clk_valid` rises exactly `LOCK_CYCLES`+4 edges after the pin rises.
- R6: A level change on any configuration pin while the clock is valid drops `clk_valid` 3 edges after the pin change. `clk_valid` returns exactly `LOCK_CYCLES`+3 edges after the change, provided no further change occurs.
- R7: A configuration change during the lock wait restarts the full wait. `clk_valid` rises `LOCK_CYCLES`+3 edges after the latest change.
- R8: `clk_valid` high implies `out_drive_en` high and `osc_pd` low.
- R9: The synchronizers reset to the open-pin levels: enable 1, spread 1, rate 11, multiply 0. With the pins at those levels, leaving reset gives `out_drive_en`=1 2 edges later and `clk_valid`=1 exactly `LOCK_CYCLES`+2 edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin | input | 1 | Output-enable pin; low requests power-down |
| spread_pin | input | 1 | Spread type selection pin |
| rate_pin | input | 2 | Modulation rate selection pins |
| mult_pin | input | 1 | Multiplication selection pin |
| osc_pd | output | 1 | Oscillator and PLL power-down control |
| out_drive_en | output | 1 | Output pad drive enable (0 = high impedance) |
| clk_valid | output | 1 | Generated clock is stable |
| eff_spread | output | 1 | Spread type passed to the generator |
| eff_rate | output | 2 | Rate select passed to the generator |
| eff_mult | output | 1 | Multiply select passed to the generator |

## Verification
Several relations are checked on every cycle:
- The valid flag never stands without the driver enabled and power-down released.
- The configuration outputs are zero whenever the driver is off.
- A filtered power-down always clears the valid flag on the next edge, and a high enable sample always restores the filtered enable.
- A configuration change seen in the valid state always drops the valid flag.

Only the bench scenarios can show the exact cycle counts of the lock wait. They also cover the restart of that wait by a change partway through, and the boundary between a glitch one cycle too short and a real power-down.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;
  localparam int CFG_W = 4;  // {spread, rate[1:0], mult}

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_LOCKING = 2'd1,
    ST_VALID   = 2'd2
  } lk_state_t;
endpackage

// File: rtl/cdc_sync2.sv
module cdc_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/oe_glitch_filt.sv
module oe_glitch_filt #(
  parameter int MIN_LOW = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic s_oe,
  output logic oe_on
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_on   <= 1'b0;
      low_cnt <= '0;
    end else if (s_oe) begin
      oe_on   <= 1'b1;
      low_cnt <= '0;
    end else if (oe_on) begin
      if (low_cnt == LAST) oe_on <= 1'b0;
      else                 low_cnt <= low_cnt + 1'b1;
    end
  end

  // R3
  reenable_chk: assert property (@(posedge clk) disable iff (rst)
    s_oe |=> oe_on);

  // R2
  fall_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_on) |-> !$past(s_oe));
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lockseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1_250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_on,
  input  logic cfg_chg,
  output logic osc_pd,
  output logic drive_en,
  output logic valid
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  lk_state_t     st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      ST_OFF: if (oe_on) begin
        st_n  = ST_LOCKING;
        cnt_n = '0;
      end
      ST_LOCKING: begin
        if (!oe_on)           st_n  = ST_OFF;
        else if (cfg_chg)     cnt_n = '0;
        else if (cnt == LAST) st_n  = ST_VALID;
        else                  cnt_n = cnt + 1'b1;
      end
      ST_VALID: begin
        if (!oe_on) st_n = ST_OFF;
        else if (cfg_chg) begin
          st_n  = ST_LOCKING;
          cnt_n = '0;
        end
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_OFF;
      cnt      <= '0;
      osc_pd   <= 1'b1;
      drive_en <= 1'b0;
      valid    <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      osc_pd   <= (st_n == ST_OFF);
      drive_en <= (st_n != ST_OFF);
      valid    <= (st_n == ST_VALID);
    end
  end

  // R8
  valid_powered_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (drive_en && !osc_pd));

  // R2
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_on |=> (!valid && !drive_en && osc_pd));
endmodule

// File: rtl/clkgen_lockseq.sv
module clkgen_lockseq
  import lockseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1_250_000,
  parameter int MIN_LOW     = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       oe_pin,
  input  logic       spread_pin,
  input  logic [1:0] rate_pin,
  input  logic       mult_pin,
  output logic       osc_pd,
  output logic       out_drive_en,
  output logic       clk_valid,
  output logic       eff_spread,
  output logic [1:0] eff_rate,
  output logic       eff_mult
);
  localparam logic [CFG_W-1:0] CFG_DEF = 4'b1110;

  logic             s_oe, oe_on, cfg_chg;
  logic [CFG_W-1:0] s_cfg, prev_cfg;

  cdc_sync2 #(.W(CFG_W + 1), .RST_VAL({1'b1, CFG_DEF})) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({oe_pin, spread_pin, rate_pin, mult_pin}),
    .q   ({s_oe, s_cfg})
  );

  oe_glitch_filt #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .s_oe  (s_oe),
    .oe_on (oe_on)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_cfg <= CFG_DEF;
    else     prev_cfg <= s_cfg;
  end
  assign cfg_chg = (s_cfg != prev_cfg);

  lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .oe_on    (oe_on),
    .cfg_chg  (cfg_chg),
    .osc_pd   (osc_pd),
    .drive_en (out_drive_en),
    .valid    (clk_valid)
  );

  always_ff @(posedge clk) begin
    if (rst || !oe_on) {eff_spread, eff_rate, eff_mult} <= '0;
    else               {eff_spread, eff_rate, eff_mult} <= s_cfg;
  end

  // R4
  eff_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
    !out_drive_en |-> ({eff_spread, eff_rate, eff_mult} == '0));

  // R6
  chg_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_chg && clk_valid) |=> !clk_valid);
endmodule

// File: tb/clkgen_lockseq_bench.sv
module clkgen_lockseq_bench;
  localparam int L = 20;
  localparam int M = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       oe_pin = 1'b1, spread_pin = 1'b1, mult_pin = 1'b0;
  logic [1:0] rate_pin = 2'b11;
  logic       osc_pd, out_drive_en, clk_valid, eff_spread, eff_mult;
  logic [1:0] eff_rate;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  clkgen_lockseq #(.LOCK_CYCLES(L), .MIN_LOW(M)) u_clkgen_lockseq (
    .clk(clk), .rst(rst), .oe_pin(oe_pin), .spread_pin(spread_pin),
    .rate_pin(rate_pin), .mult_pin(mult_pin), .osc_pd(osc_pd),
    .out_drive_en(out_drive_en), .clk_valid(clk_valid),
    .eff_spread(eff_spread), .eff_rate(eff_rate), .eff_mult(eff_mult)
  );

  // {spread, rate[1:0], mult}; each differs from the one before
  localparam logic [3:0] VEC [6] = '{4'b0000, 4'b1011, 4'b0101,
                                     4'b1111, 4'b0110, 4'b1110};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic pd, input logic dr, input logic v);
    chk(osc_pd == pd && out_drive_en == dr && clk_valid == v, req,
        {osc_pd, out_drive_en, clk_valid}, {pd, dr, v});
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {spread_pin, rate_pin, mult_pin} = c;
  endtask

  function automatic logic [3:0] eff_now();
    return {eff_spread, eff_rate, eff_mult};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    // R1 reset state
    chk_out("R1", 1'b1, 1'b0, 1'b0);
    chk(eff_now() == 4'b0, "R1 eff", eff_now(), 0);
    rst = 1'b0;
    // R9 default pins leave reset without a spurious change
    step(1);
    chk_out("R1 first cycle", 1'b1, 1'b0, 1'b0);
    step(1);
    chk_out("R9 drive", 1'b0, 1'b1, 1'b0);
    step(L - 1);
    chk_out("R9 before valid", 1'b0, 1'b1, 1'b0);
    step(1);
    chk_out("R9 valid", 1'b0, 1'b1, 1'b1);
    chk(eff_now() == 4'b1110, "R9 eff default", eff_now(), 4'b1110);

    // R6 / R4 vector walk
    for (int i = 0; i < 6; i++) begin
      set_cfg(VEC[i]);
      step(3);
      chk(clk_valid == 1'b0, "R6 drop", clk_valid, 0);
      step(L - 1);
      chk(clk_valid == 1'b0, "R6 still locking", clk_valid, 0);
      chk(eff_now() == VEC[i], "R4 follow", eff_now(), VEC[i]);
      step(1);
      chk(clk_valid == 1'b1, "R6 relock", clk_valid, 1);
    end

    // R7 change mid-wait restarts
    set_cfg(4'b0011);
    step(8);
    set_cfg(4'b1001);
    step(L + 2);
    chk(clk_valid == 1'b0, "R7 restarted", clk_valid, 0);
    step(1);
    chk(clk_valid == 1'b1, "R7 valid", clk_valid, 1);

    // R3 short low pulse ignored
    oe_pin = 1'b0;
    step(M - 1);
    oe_pin = 1'b1;
    for (int k = 0; k < L + 8; k++) begin
      step(1);
      chk(clk_valid && out_drive_en, "R3 glitch", {clk_valid, out_drive_en}, 3);
    end

    // R2 real power-down
    oe_pin = 1'b0;
    step(M + 3);
    chk_out("R2 off", 1'b1, 1'b0, 1'b0);
    chk(eff_now() == 4'b0, "R4 zero when off", eff_now(), 0);
    set_cfg(4'b1101);
    step(5);
    chk(eff_now() == 4'b0, "R4 pins ignored off", eff_now(), 0);
    chk_out("R2 stays off", 1'b1, 1'b0, 1'b0);

    // R5 power-down exit
    oe_pin = 1'b1;
    step(3);
    chk_out("R5 not yet", 1'b1, 1'b0, 1'b0);
    step(1);
    chk_out("R5 drive", 1'b0, 1'b1, 1'b0);
    chk(eff_now() == 4'b1101, "R4 follow after on", eff_now(), 4'b1101);
    step(L - 1);
    chk_out("R5 before valid", 1'b0, 1'b1, 1'b0);
    step(1);
    chk_out("R5 valid", 1'b0, 1'b1, 1'b1);

    // R1 reset mid-run
    rst = 1'b1;
    step(1);
    chk_out("R1 mid-run", 1'b1, 1'b0, 1'b0);
    chk(eff_now() == 4'b0, "R1 eff mid-run", eff_now(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule